// File: doc/BRIEF.md
# Multi-Context Configuration Plane Controller

This block manages a small cache of configuration planes for a reconfigurable datapath that sits beside a processor. There are four planes. At any moment at most one of them is active and carries execute traffic. Any other plane can be rewritten in the background from a configuration memory. The processor issues two kinds of command. A load names an operation code, a target plane, the latency and minimum issue spacing of the mapped function, and is followed by a fixed number of configuration words. An execute names an operation code, two source operands and a destination register tag, and is sent to the plane that holds that operation.

The configurable array is modelled by a stub. A plane's "configuration" folds into a key, the XOR of all words loaded into that plane. An operation returns `(src_a + src_b) XOR key` after the plane's latency. Switching to another valid plane costs one stall cycle. A load finished ahead of time therefore adds no reconfiguration delay. Results leave in issue order.

The load command, configuration word and execute ports are valid/ready streams. A transfer happens on any clock edge where both valid and ready are high. The sender must hold valid and its payload stable until that edge. The ready signals never depend on back-pressure from downstream, because the result port has no ready: `res_valid` is a one-cycle pulse that the consumer must take. `ld_err`, `ex_busy`, `active_plane` and `plane_valid` are plain status pins.

Top module: `cfg_plane_ctrl`

## Requirements
- R1: After reset all four planes are invalid and no plane is active. `ld_ready` is 1, while `ex_ready`, `res_valid` and `ld_err` are 0.
- R2: An accepted load command that is not refused has these effects. `plane_valid` of the target is 0 from the next cycle on. `ld_ready` stays 0 while exactly CFG_WORDS words are taken on `cw_valid`/`cw_ready`. The target's valid bit is 1 from the cycle after the last word.
- R3: A load command is refused when its target is the active plane, or when its target is the plane being switched to in that same cycle. A refused command is consumed, and `ld_err` is 1 for exactly the next cycle. No configuration words are taken. The active plane keeps its valid bit and its key.
- R4: A load into a non-active plane runs alongside execution. Back-to-back executes on the active plane are still accepted every cycle when its issue delay is 1.
- R5: An execute whose operation sits in a valid plane other than the active one has `ex_ready` at 0 for exactly one cycle. During that cycle `active_plane` takes the new plane. The execute can be accepted in the following cycle.
- R6: An execute whose operation is in no valid plane keeps `ex_ready` at 0 until a matching load completes. It is then accepted two cycles after the last word: one cycle for the valid bit and one switch cycle.
- R7: When several valid planes hold the requested operation code, the lowest-numbered one is used.
- R8: For an execute accepted in cycle c on a plane with latency field L (0 is treated as 1), `res_valid` is 1 in cycle c+L. In that cycle `res_data` = (src_a + src_b) mod 2^DATA_W XOR the plane's key, and `res_dst` equals `ex_dst`.
- R9: With issue-delay field G (0 is treated as 1), two executes on the same plane are accepted at least G cycles apart. `ex_busy` is 1 while a valid execute on the active plane is held for this reason.
- R10: Results appear in the order their executes were accepted. An execute whose latency would let it overtake an earlier one is held with `ex_ready` at 0 until that can no longer happen.
- R11: An operation already accepted completes with its original result even if a load or a plane switch starts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load command valid |
| ld_ready | output | 1 | Load command ready (loader idle) |
| ld_plane | input | PLANE_W | Target plane of the load |
| ld_op | input | OP_W | Operation code the plane will hold |
| ld_lat | input | LAT_W | Latency of the mapped function |
| ld_gap | input | LAT_W | Minimum issue spacing of the mapped function |
| ld_err | output | 1 | One-cycle pulse after a refused load |
| cw_valid | input | 1 | Configuration word valid |
| cw_ready | output | 1 | Configuration word ready (loader streaming) |
| cw_data | input | DATA_W | Configuration word |
| ex_valid | input | 1 | Execute command valid |
| ex_ready | output | 1 | Execute command ready |
| ex_busy | output | 1 | Execute held by the plane's issue delay |
| ex_op | input | OP_W | Requested operation code |
| ex_src_a | input | DATA_W | First operand |
| ex_src_b | input | DATA_W | Second operand |
| ex_dst | input | REG_W | Destination register tag |
| res_valid | output | 1 | Result pulse |
| res_data | output | DATA_W | Result value |
| res_dst | output | REG_W | Destination tag of the result |
| active_plane | output | PLANE_W | Currently active plane |
| plane_valid | output | NUM_PLANES | Valid bit per plane |

## Verification
The bound checker watches several rules on every cycle. An accepted load clears its target's valid bit. The word port and the command port are never ready together. A refused load produces `ld_err`. A switch cycle stalls and installs the matched plane. The active plane stays valid. An accept happens only on a valid active plane. A second accept on a plane with spacing of two or more is not allowed in the next cycle. Some properties need the values a sequence of commands produces, and only the bench scenarios can show them. These are the exact result values, the latency to the cycle, the order of results across planes of different latency, the two-cycle wake-up after a stalled execute's load, and lowest-plane selection among duplicates.

// File: rtl/cfg_plane_pkg.sv
`timescale 1ns/1ps
package cfg_plane_pkg;

  typedef enum logic {
    LD_IDLE   = 1'b0,
    LD_STREAM = 1'b1
  } ld_state_e;

  function automatic int ctr_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cfg_plane_bank.sv
`timescale 1ns/1ps
module cfg_plane_bank
  import cfg_plane_pkg::*;
#(
  parameter int NUM_PLANES = 4,
  parameter int PLANE_W    = 2,
  parameter int OP_W       = 6,
  parameter int LAT_W      = 4,
  parameter int DATA_W     = 32,
  parameter int CFG_WORDS  = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               ld_valid,
  output logic                               ld_ready,
  input  logic [PLANE_W-1:0]                 ld_plane,
  input  logic [OP_W-1:0]                    ld_op,
  input  logic [LAT_W-1:0]                   ld_lat,
  input  logic [LAT_W-1:0]                   ld_gap,
  input  logic                               ld_block,
  output logic                               ld_err,
  input  logic                               cw_valid,
  output logic                               cw_ready,
  input  logic [DATA_W-1:0]                  cw_data,
  output logic [NUM_PLANES-1:0]              plane_valid,
  output logic [NUM_PLANES-1:0][OP_W-1:0]    plane_op,
  output logic [NUM_PLANES-1:0][LAT_W-1:0]   plane_lat,
  output logic [NUM_PLANES-1:0][LAT_W-1:0]   plane_gap,
  output logic [NUM_PLANES-1:0][DATA_W-1:0]  plane_key
);

  localparam int CNT_W = ctr_width(CFG_WORDS);

  ld_state_e          state_q;
  logic [PLANE_W-1:0] tgt_q;
  logic [CNT_W-1:0]   wcnt_q;
  logic               ld_fire;
  logic               ld_take;
  logic               cw_fire;
  logic               cw_last;

  assign ld_ready = (state_q == LD_IDLE);
  assign cw_ready = (state_q == LD_STREAM);
  assign ld_fire  = ld_valid && ld_ready;
  assign ld_take  = ld_fire && !ld_block;
  assign cw_fire  = cw_valid && cw_ready;
  assign cw_last  = cw_fire && (wcnt_q == CNT_W'(CFG_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      tgt_q   <= '0;
      wcnt_q  <= '0;
      ld_err  <= 1'b0;
    end else begin
      ld_err <= ld_fire && ld_block;
      if (ld_take) begin
        state_q <= LD_STREAM;
        tgt_q   <= ld_plane;
        wcnt_q  <= '0;
      end else if (cw_fire) begin
        wcnt_q <= wcnt_q + CNT_W'(1);
        if (cw_last) state_q <= LD_IDLE;
      end
    end
  end

  // one register set per plane
  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    logic start_here;
    logic word_here;
    assign start_here = ld_take && (ld_plane == PLANE_W'(p));
    assign word_here  = cw_fire && (tgt_q == PLANE_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        plane_valid[p] <= 1'b0;
        plane_op[p]    <= '0;
        plane_lat[p]   <= '0;
        plane_gap[p]   <= '0;
        plane_key[p]   <= '0;
      end else if (start_here) begin
        plane_valid[p] <= 1'b0;
        plane_op[p]    <= ld_op;
        plane_lat[p]   <= ld_lat;
        plane_gap[p]   <= ld_gap;
        plane_key[p]   <= '0;
      end else if (word_here) begin
        plane_key[p] <= plane_key[p] ^ cw_data;
        if (cw_last) plane_valid[p] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfg_plane_match.sv
`timescale 1ns/1ps
module cfg_plane_match #(
  parameter int NUM_PLANES = 4,
  parameter int PLANE_W    = 2,
  parameter int OP_W       = 6
) (
  input  logic [NUM_PLANES-1:0]            plane_valid,
  input  logic [NUM_PLANES-1:0][OP_W-1:0]  plane_op,
  input  logic [OP_W-1:0]                  want_op,
  output logic                             hit,
  output logic [PLANE_W-1:0]               idx
);

  logic [NUM_PLANES-1:0] eq;

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_cmp
    assign eq[p] = plane_valid[p] && (plane_op[p] == want_op);
  end

  // scan from the top so the lowest matching plane wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int p = NUM_PLANES - 1; p >= 0; p--) begin
      if (eq[p]) begin
        hit = 1'b1;
        idx = PLANE_W'(p);
      end
    end
  end

endmodule

// File: rtl/cfg_issue_pipe.sv
`timescale 1ns/1ps
module cfg_issue_pipe #(
  parameter int LAT_W  = 4,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [LAT_W-1:0]  issue_lat,
  input  logic [DATA_W-1:0] issue_data,
  input  logic [REG_W-1:0]  issue_dst,
  output logic              order_ok,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [REG_W-1:0]  res_dst
);

  localparam int MAX_LAT = (1 << LAT_W) - 1;

  logic [MAX_LAT-1:0] occ;
  logic [DATA_W-1:0]  sdata [MAX_LAT];
  logic [REG_W-1:0]   sdst  [MAX_LAT];

  // slot i reaches the output i cycles from now
  for (genvar i = 0; i < MAX_LAT; i++) begin : g_slot
    logic load_here;
    assign load_here = issue && (issue_lat == LAT_W'(i + 1));
    if (i == MAX_LAT - 1) begin : g_top
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          occ[i]   <= 1'b0;
          sdata[i] <= '0;
          sdst[i]  <= '0;
        end else if (load_here) begin
          occ[i]   <= 1'b1;
          sdata[i] <= issue_data;
          sdst[i]  <= issue_dst;
        end else begin
          occ[i] <= 1'b0;
        end
      end
    end else begin : g_mid
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          occ[i]   <= 1'b0;
          sdata[i] <= '0;
          sdst[i]  <= '0;
        end else if (load_here) begin
          occ[i]   <= 1'b1;
          sdata[i] <= issue_data;
          sdst[i]  <= issue_dst;
        end else begin
          occ[i]   <= occ[i+1];
          sdata[i] <= sdata[i+1];
          sdst[i]  <= sdst[i+1];
        end
      end
    end
  end

  // a new entry must land above every older entry after the shift
  always_comb begin
    order_ok = 1'b1;
    for (int k = 1; k < MAX_LAT; k++) begin
      if (occ[k] && (int'(issue_lat) <= k)) order_ok = 1'b0;
    end
  end

  assign res_valid = occ[0];
  assign res_data  = sdata[0];
  assign res_dst   = sdst[0];

endmodule

// File: rtl/cfg_plane_ctrl.sv
`timescale 1ns/1ps
module cfg_plane_ctrl #(
  parameter int NUM_PLANES = 4,
  parameter int OP_W       = 6,
  parameter int LAT_W      = 4,
  parameter int DATA_W     = 32,
  parameter int REG_W      = 5,
  parameter int CFG_WORDS  = 8,
  localparam int PLANE_W   = $clog2(NUM_PLANES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_valid,
  output logic                  ld_ready,
  input  logic [PLANE_W-1:0]    ld_plane,
  input  logic [OP_W-1:0]       ld_op,
  input  logic [LAT_W-1:0]      ld_lat,
  input  logic [LAT_W-1:0]      ld_gap,
  output logic                  ld_err,
  input  logic                  cw_valid,
  output logic                  cw_ready,
  input  logic [DATA_W-1:0]     cw_data,
  input  logic                  ex_valid,
  output logic                  ex_ready,
  output logic                  ex_busy,
  input  logic [OP_W-1:0]       ex_op,
  input  logic [DATA_W-1:0]     ex_src_a,
  input  logic [DATA_W-1:0]     ex_src_b,
  input  logic [REG_W-1:0]      ex_dst,
  output logic                  res_valid,
  output logic [DATA_W-1:0]     res_data,
  output logic [REG_W-1:0]      res_dst,
  output logic [PLANE_W-1:0]    active_plane,
  output logic [NUM_PLANES-1:0] plane_valid
);

  logic [NUM_PLANES-1:0][OP_W-1:0]   plane_op;
  logic [NUM_PLANES-1:0][LAT_W-1:0]  plane_lat;
  logic [NUM_PLANES-1:0][LAT_W-1:0]  plane_gap;
  logic [NUM_PLANES-1:0][DATA_W-1:0] plane_key;
  logic [NUM_PLANES-1:0][LAT_W-1:0]  gcnt;

  logic               have_active;
  logic [PLANE_W-1:0] act_q;
  logic               match_hit;
  logic [PLANE_W-1:0] match_idx;
  logic               sel_live;
  logic               switch_req;
  logic               ld_block;
  logic               gap_ok;
  logic               order_ok;
  logic               ex_fire;
  logic [LAT_W-1:0]   lat_sel;
  logic [LAT_W-1:0]   gap_sel;
  logic [DATA_W-1:0]  issue_data;

  cfg_plane_bank #(
    .NUM_PLANES(NUM_PLANES), .PLANE_W(PLANE_W), .OP_W(OP_W),
    .LAT_W(LAT_W), .DATA_W(DATA_W), .CFG_WORDS(CFG_WORDS)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_plane(ld_plane),
    .ld_op(ld_op), .ld_lat(ld_lat), .ld_gap(ld_gap),
    .ld_block(ld_block), .ld_err(ld_err),
    .cw_valid(cw_valid), .cw_ready(cw_ready), .cw_data(cw_data),
    .plane_valid(plane_valid), .plane_op(plane_op),
    .plane_lat(plane_lat), .plane_gap(plane_gap), .plane_key(plane_key)
  );

  cfg_plane_match #(
    .NUM_PLANES(NUM_PLANES), .PLANE_W(PLANE_W), .OP_W(OP_W)
  ) u_match (
    .plane_valid(plane_valid), .plane_op(plane_op), .want_op(ex_op),
    .hit(match_hit), .idx(match_idx)
  );

  assign lat_sel = (plane_lat[match_idx] == '0) ? LAT_W'(1) : plane_lat[match_idx];
  assign gap_sel = (plane_gap[match_idx] == '0) ? LAT_W'(1) : plane_gap[match_idx];

  assign sel_live   = match_hit && have_active && (match_idx == act_q);
  assign switch_req = ex_valid && match_hit && !sel_live;
  assign gap_ok     = (gcnt[match_idx] == '0);
  assign ex_ready   = sel_live && gap_ok && order_ok;
  assign ex_busy    = ex_valid && sel_live && !gap_ok;
  assign ex_fire    = ex_valid && ex_ready;
  assign issue_data = (ex_src_a + ex_src_b) ^ plane_key[match_idx];

  assign ld_block = (have_active && (ld_plane == act_q)) ||
                    (switch_req && (ld_plane == match_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q       <= '0;
      have_active <= 1'b0;
    end else if (switch_req) begin
      act_q       <= match_idx;
      have_active <= 1'b1;
    end
  end

  // issue spacing counter per plane
  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_gap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gcnt[p] <= '0;
      end else if (ex_fire && (act_q == PLANE_W'(p))) begin
        gcnt[p] <= gap_sel - LAT_W'(1);
      end else if (gcnt[p] != '0) begin
        gcnt[p] <= gcnt[p] - LAT_W'(1);
      end
    end
  end

  cfg_issue_pipe #(
    .LAT_W(LAT_W), .DATA_W(DATA_W), .REG_W(REG_W)
  ) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .issue(ex_fire), .issue_lat(lat_sel), .issue_data(issue_data),
    .issue_dst(ex_dst), .order_ok(order_ok),
    .res_valid(res_valid), .res_data(res_data), .res_dst(res_dst)
  );

  assign active_plane = act_q;

endmodule

// File: rtl/cfg_plane_ctrl_chk.sv
`timescale 1ns/1ps
module cfg_plane_ctrl_chk #(
  parameter int NUM_PLANES = 4,
  parameter int PLANE_W    = 2,
  parameter int LAT_W      = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ld_valid,
  input logic                  ld_ready,
  input logic [PLANE_W-1:0]    ld_plane,
  input logic                  ld_err,
  input logic                  cw_ready,
  input logic                  ex_valid,
  input logic                  ex_ready,
  input logic [PLANE_W-1:0]    active_plane,
  input logic [NUM_PLANES-1:0] plane_valid,
  input logic                  have_active,
  input logic                  switch_req,
  input logic [PLANE_W-1:0]    match_idx,
  input logic [LAT_W-1:0]      gap_sel
);

  logic ld_fire;
  logic refuse_seen;
  assign ld_fire     = ld_valid && ld_ready;
  assign refuse_seen = ld_fire && ((have_active && (ld_plane == active_plane)) ||
                                   (switch_req && (ld_plane == match_idx)));

  // R2
  load_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && !refuse_seen) |=> !plane_valid[$past(ld_plane)]);

  // R2
  port_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_ready |-> !ld_ready);

  // R3
  refuse_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_seen |=> ld_err);

  // R3
  active_stays_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    have_active |-> plane_valid[active_plane]);

  // R5
  switch_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_req |-> !ex_ready);

  // R5
  switch_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_req |=> (active_plane == $past(match_idx)));

  // R6
  accept_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_ready |-> (have_active && plane_valid[active_plane]));

  // R9
  issue_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_ready && (gap_sel >= LAT_W'(2)))
      |=> !(ex_valid && ex_ready && (active_plane == $past(active_plane))));

endmodule

bind cfg_plane_ctrl cfg_plane_ctrl_chk #(
  .NUM_PLANES(NUM_PLANES), .PLANE_W(PLANE_W), .LAT_W(LAT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .ld_plane(ld_plane), .ld_err(ld_err), .cw_ready(cw_ready),
  .ex_valid(ex_valid), .ex_ready(ex_ready), .active_plane(active_plane),
  .plane_valid(plane_valid), .have_active(have_active),
  .switch_req(switch_req), .match_idx(match_idx), .gap_sel(gap_sel)
);

// File: tb/sim_cfg_plane_ctrl.sv
`timescale 1ns/1ps
module sim_cfg_plane_ctrl;

  localparam int NP = 4;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [1:0]  ld_plane = '0;
  logic [5:0]  ld_op = '0;
  logic [3:0]  ld_lat = '0;
  logic [3:0]  ld_gap = '0;
  logic        ld_err;
  logic        cw_valid = 1'b0;
  logic        cw_ready;
  logic [31:0] cw_data = '0;
  logic        ex_valid = 1'b0;
  logic        ex_ready;
  logic        ex_busy;
  logic [5:0]  ex_op = '0;
  logic [31:0] ex_src_a = '0;
  logic [31:0] ex_src_b = '0;
  logic [4:0]  ex_dst = '0;
  logic        res_valid;
  logic [31:0] res_data;
  logic [4:0]  res_dst;
  logic [1:0]  active_plane;
  logic [3:0]  plane_valid;

  cfg_plane_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_plane(ld_plane),
    .ld_op(ld_op), .ld_lat(ld_lat), .ld_gap(ld_gap), .ld_err(ld_err),
    .cw_valid(cw_valid), .cw_ready(cw_ready), .cw_data(cw_data),
    .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_busy(ex_busy),
    .ex_op(ex_op), .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_dst(ex_dst),
    .res_valid(res_valid), .res_data(res_data), .res_dst(res_dst),
    .active_plane(active_plane), .plane_valid(plane_valid)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model state
  bit          mv [NP];
  logic [5:0]  mop [NP];
  int          mlat [NP];
  int          mgap [NP];
  logic [31:0] mkey [NP];
  int          last_acc [NP];
  int          mact = 0;
  bit          mhave = 0;
  int          ld_tgt = 0;
  logic [31:0] ld_acc = '0;
  int          ld_cnt = 0;
  bit          exp_err = 0;
  int          acc_cyc = 0;
  int          cwdone_cyc = 0;

  typedef struct {
    logic [31:0] d;
    logic [4:0]  r;
    int          due;
  } exp_t;
  exp_t q[$];

  initial begin
    for (int p = 0; p < NP; p++) begin
      mv[p] = 0; mop[p] = '0; mlat[p] = 0; mgap[p] = 0; mkey[p] = '0;
      last_acc[p] = -1000;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit hit; int m; bit sw; bit nerr; int lat; int gp; exp_t e;
      // results: R8 value and timing, R10 order
      if (res_valid) begin
        if (q.size() == 0) chk(0, "R10 unexpected result", res_data, 0);
        else begin
          e = q.pop_front();
          chk(res_data == e.d, "R8 result data", res_data, e.d);
          chk(res_dst == e.r, "R8 result dst", res_dst, e.r);
          chk(cyc == e.due, "R8 result cycle", cyc, e.due);
        end
      end else if (q.size() > 0 && q[0].due <= cyc) begin
        chk(0, "R10 missing result", cyc, q[0].due);
        void'(q.pop_front());
      end
      if (exp_err || ld_err) chk(ld_err == exp_err, "R3 ld_err pulse", ld_err, exp_err);
      chk(active_plane == 2'(mact), "R5 active plane", active_plane, mact);
      chk(plane_valid == {mv[3], mv[2], mv[1], mv[0]}, "R2 valid bits",
          plane_valid, {mv[3], mv[2], mv[1], mv[0]});
      hit = 0; m = 0;
      for (int p = NP - 1; p >= 0; p--) if (mv[p] && mop[p] == ex_op) begin hit = 1; m = p; end
      sw = ex_valid && hit && (!mhave || m != mact);
      if (ex_valid && ex_ready) begin
        chk(hit && !sw, "R6 accept only on valid active plane", ex_ready, 0);
        lat = (mlat[m] == 0) ? 1 : mlat[m];
        gp  = (mgap[m] == 0) ? 1 : mgap[m];
        chk(cyc - last_acc[m] >= gp, "R9 issue spacing", cyc - last_acc[m], gp);
        e.d = (ex_src_a + ex_src_b) ^ mkey[m];
        e.r = ex_dst;
        e.due = cyc + lat;
        q.push_back(e);
        last_acc[m] = cyc;
        acc_cyc = cyc;
      end
      if (sw) chk(!ex_ready, "R5 switch cycle stalls", ex_ready, 0);
      if (ex_valid && !hit) chk(!ex_ready, "R6 stall on missing op", ex_ready, 0);
      nerr = 0;
      if (ld_valid && ld_ready) begin
        if ((mhave && int'(ld_plane) == mact) || (sw && int'(ld_plane) == m)) nerr = 1;
        else begin
          mv[ld_plane] = 0; mop[ld_plane] = ld_op;
          mlat[ld_plane] = ld_lat; mgap[ld_plane] = ld_gap;
          ld_tgt = ld_plane; ld_acc = '0; ld_cnt = 0;
        end
      end
      if (cw_valid && cw_ready) begin
        ld_acc = ld_acc ^ cw_data;
        ld_cnt++;
        if (ld_cnt == NW) begin
          mv[ld_tgt] = 1; mkey[ld_tgt] = ld_acc; cwdone_cyc = cyc;
        end
      end
      if (sw) begin mact = m; mhave = 1; end
      exp_err = nerr;
    end
  end

  // every driver task starts just after a rising edge
  task automatic do_ex(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] d);
    ex_valid = 1; ex_op = op; ex_src_a = a; ex_src_b = b; ex_dst = d;
    do @(negedge clk); while (!ex_ready);
    @(posedge clk); #1;
    ex_valid = 0;
  endtask

  task automatic do_ld(input int p, input logic [5:0] op, input int lat, input int gap,
                       input bit refused);
    ld_valid = 1; ld_plane = 2'(p); ld_op = op; ld_lat = 4'(lat); ld_gap = 4'(gap);
    do @(negedge clk); while (!ld_ready);
    @(posedge clk); #1;
    ld_valid = 0;
    if (!refused) begin
      for (int w = 0; w < NW; w++) begin
        cw_valid = 1; cw_data = $urandom;
        do @(negedge clk); while (!cw_ready);
        @(posedge clk); #1;
      end
      cw_valid = 0;
    end
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired (all requirements) actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    int s; int a1; int prev; logic [5:0] ops [4];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ld_ready == 1, "R1 ld_ready after reset", ld_ready, 1);
    chk(ex_ready == 0, "R1 ex_ready after reset", ex_ready, 0);
    chk(plane_valid == 0, "R1 planes invalid", plane_valid, 0);
    chk(res_valid == 0 && ld_err == 0, "R1 outputs idle", {res_valid, ld_err}, 0);
    @(posedge clk); #1 rst_n = 1;
    @(posedge clk); #1;

    // R2 load, then R5 first execute switches once
    do_ld(0, 6'd5, 3, 1, 0);
    @(negedge clk);
    chk(plane_valid[0] == 1, "R2 valid after last word", plane_valid, 1);
    @(posedge clk); #1;
    s = cyc;
    do_ex(6'd5, 32'd10, 32'd20, 5'd1);
    chk(acc_cyc == s + 1, "R5 one switch cycle", acc_cyc, s + 1);
    drain();

    // R3 refused load to active plane
    do_ld(0, 6'd11, 2, 1, 1);
    @(negedge clk);
    chk(plane_valid[0] == 1, "R3 active stays valid", plane_valid, 1);
    chk(ld_ready == 1, "R3 no words taken", ld_ready, 1);
    @(posedge clk); #1;
    s = cyc;
    do_ex(6'd5, 32'hFFFF_FFFF, 32'd2, 5'd2);
    chk(acc_cyc == s, "R3 active config intact", acc_cyc, s);

    // R4 and R11: background load while streaming executes
    fork
      do_ld(1, 6'd7, 2, 4, 0);
      begin
        prev = -1;
        for (int i = 0; i < 10; i++) begin
          do_ex(6'd5, $urandom, $urandom, 5'(i));
          if (prev >= 0) chk(acc_cyc == prev + 1, "R4 full rate during load", acc_cyc, prev + 1);
          prev = acc_cyc;
        end
      end
    join
    drain();

    // R9 issue spacing with ex_busy
    do_ex(6'd7, 32'd1, 32'd2, 5'd3);
    a1 = acc_cyc;
    fork
      do_ex(6'd7, 32'd3, 32'd4, 5'd4);
      begin
        @(negedge clk);
        chk(ex_busy == 1, "R9 busy while spaced", ex_busy, 1);
      end
    join
    chk(acc_cyc == a1 + 4, "R9 second issue after gap", acc_cyc, a1 + 4);
    drain();

    // R6 stall until load of the missing op completes
    fork
      do_ex(6'd9, 32'd7, 32'd8, 5'd5);
      begin
        repeat (6) @(negedge clk);
        chk(ex_ready == 0, "R6 held without plane", ex_ready, 0);
        @(posedge clk); #1;
        do_ld(2, 6'd9, 6, 1, 0);
      end
    join
    chk(acc_cyc == cwdone_cyc + 2, "R6 wake two cycles after load", acc_cyc, cwdone_cyc + 2);
    drain();

    // R10 and R11: long op then short op on another plane
    do_ex(6'd9, 32'd100, 32'd1, 5'd6);
    a1 = acc_cyc;
    do_ex(6'd7, 32'd200, 32'd2, 5'd7);
    chk(acc_cyc == a1 + 5, "R10 short op held for order", acc_cyc, a1 + 5);
    drain();

    // R7 duplicate op codes
    do_ld(3, 6'd7, 1, 1, 0);
    do_ex(6'd7, 32'd5, 32'd5, 5'd8);
    @(negedge clk);
    chk(active_plane == 2'd1, "R7 lowest plane chosen", active_plane, 1);
    @(posedge clk); #1;
    do_ex(6'd5, 32'd1, 32'd1, 5'd9);
    do_ld(1, 6'd12, 2, 1, 0);
    do_ex(6'd7, 32'd9, 32'd9, 5'd10);
    @(negedge clk);
    chk(active_plane == 2'd3, "R7 next plane after reload", active_plane, 3);
    @(posedge clk); #1;
    drain();

    // constrained random traffic
    ops[0] = 6'd5; ops[1] = 6'd12; ops[2] = 6'd9; ops[3] = 6'd7;
    for (int i = 0; i < 400; i++) begin
      int p;
      if (i % 100 == 50) begin
        p = int'($urandom_range(0, 3));
        if (p == int'(active_plane)) p = (p + 1) % NP;
        do_ld(p, ops[p], int'($urandom_range(0, 8)), int'($urandom_range(0, 3)), 0);
      end
      do_ex(ops[$urandom_range(0, 3)], $urandom, $urandom, 5'($urandom));
      repeat ($urandom_range(0, 2)) begin @(posedge clk); #1; end
    end
    drain();
    finish_run();
  end

endmodule